// File: doc/BRIEF.md
# Self-Triggered Hit Frame Buffer with Crossing Stamp

This block records digital hit snapshots for a bank of discriminator channels. Each channel delivers a 2-bit hit code. The code comes from comparators set at more than one threshold, and the lowest of them sits near half a minimum-ionising signal. Whenever the trigger input is high (some channel crossed threshold), the block writes one fixed-width frame into an internal buffer. The frame holds a constant header, the current bunch-crossing number and the hit codes of every channel, including the channels that stayed quiet.

A counter driven by a bunch-crossing strobe numbers the crossings, and the acquisition-start input clears it. A readout request switches the block from acquisition to readout. It then shifts out the stored frames one bit per readout strobe, newest frame first. The buffer is empty once the last frame has been shifted out.

All activity runs on one system clock. The bunch-crossing and readout rates reach the block as single-cycle strobes, so the surrounding logic sets the rates.

Top module: `hit_mem_top`

## Requirements
- R1: After reset, frame_cnt is 0, and mem_full, rd_busy and ser_valid are all 0.
- R2: In acquisition, a cycle with trig high stores the frame {HDR, crossing number, hits} and raises frame_cnt by one on the next clock edge. This applies when no frame was stored yet in the current crossing and the buffer is not full.
- R3: At most one frame is stored per bunch crossing. A crossing ends at a clock edge where bx_tick is high. Further trigger cycles before that edge store nothing.
- R4: The crossing number is BCID_W bits wide. It increments by one at every edge with bx_tick high, wraps from all-ones to 0, and is captured as it stands before that increment.
- R5: When frame_cnt equals DEPTH, mem_full is 1 and triggers store nothing. frame_cnt and the stored frames stay unchanged.
- R6: Readout returns the stored frames in reverse order of writing, last written first.
- R7: Each frame is sent most significant bit first as an 8-bit header, then the BCID_W-bit crossing number, then the hit codes. Channel c occupies hits[2c+1:2c]. Channel NCH-1 goes out first, and within a channel the upper code bit goes out first.
- R8: While ser_valid is 1, ser_out holds its bit until a clock edge with rd_tick high, which advances it by one bit.
- R9: Triggers store nothing while rd_busy is 1. After the last bit, frame_cnt is 0 and both rd_busy and mem_full are 0.
- R10: A readout request with frame_cnt 0 does not start a readout.
- R11: acq_start clears frame_cnt and the crossing number, abandons any readout in progress and clears the one-frame-per-crossing lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_start | input | 1 | Start of acquisition: clears count, crossing number, readout |
| bx_tick | input | 1 | One-cycle strobe per bunch crossing |
| trig | input | 1 | Any channel above threshold |
| hits | input | 2*NCH | Hit codes, channel c at bits [2c+1:2c] |
| rd_req | input | 1 | Request to read out the buffer |
| rd_tick | input | 1 | Readout bit strobe |
| ser_out | output | 1 | Serial frame data |
| ser_valid | output | 1 | ser_out carries a frame bit |
| rd_busy | output | 1 | Readout in progress |
| mem_full | output | 1 | All DEPTH frames written |
| frame_cnt | output | $clog2(DEPTH+1) | Frames held in the buffer |

## Verification
The bench builds the block with four channels, a depth of four frames, a 6-bit crossing counter and a header of C3 hex, which makes each frame 22 bits long. With these values the buffer fills after four accepted triggers, so the full condition and the rejected trigger that follows it are cheap to reach. The crossing counter also wraps within seventy strobes, so a wrapped crossing number can be compared bit for bit in the serial stream. Readouts are also run with a toggling bit strobe, with a trigger applied while busy, and with an abort part way through a frame.

// File: rtl/hit_mem_pkg.sv
package hit_mem_pkg;

    localparam int HDR_W = 8;

    typedef enum logic {
        CTL_ACQ  = 1'b0,
        CTL_READ = 1'b1
    } ctl_state_e;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_LOAD  = 2'd1,
        SER_SHIFT = 2'd2
    } ser_state_e;

endpackage

// File: rtl/hit_bcid_ctr.sv
module hit_bcid_ctr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] bcid
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bcid = st_q.cnt;

endmodule

// File: rtl/hit_frame_store.sv
module hit_frame_store #(
    parameter int FW    = 160,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [FW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [FW-1:0] rdata
);

    logic [FW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/hit_readout.sv
module hit_readout
    import hit_mem_pkg::*;
#(
    parameter int FW  = 160,
    localparam int BW = $clog2(FW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic          tick,
    input  logic          last_frame,
    input  logic [FW-1:0] frame_in,
    output logic          ser_out,
    output logic          ser_valid,
    output logic          frame_done
);

    typedef struct packed {
        ser_state_e    st;
        logic [FW-1:0] sh;
        logic [BW-1:0] pos;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        frame_done = 1'b0;
        if (abort) begin
            s_d.st = SER_IDLE;
        end else begin
            case (s_q.st)
                SER_IDLE: begin
                    if (start) begin
                        s_d.st = SER_LOAD;
                    end
                end
                SER_LOAD: begin
                    s_d.sh  = frame_in;
                    s_d.pos = '0;
                    s_d.st  = SER_SHIFT;
                end
                SER_SHIFT: begin
                    if (tick) begin
                        if (s_q.pos == BW'(FW - 1)) begin
                            frame_done = 1'b1;
                            s_d.st     = last_frame ? SER_IDLE : SER_LOAD;
                        end else begin
                            s_d.sh  = {s_q.sh[FW-2:0], 1'b0};
                            s_d.pos = s_q.pos + BW'(1);
                        end
                    end
                end
                default: s_d.st = SER_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= SER_IDLE;
            s_q.sh  <= '0;
            s_q.pos <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser_out   = s_q.sh[FW-1];
    assign ser_valid = (s_q.st == SER_SHIFT);

endmodule

// File: rtl/hit_mem_top.sv
module hit_mem_top
    import hit_mem_pkg::*;
#(
    parameter int               NCH    = 64,
    parameter int               DEPTH  = 128,
    parameter int               BCID_W = 24,
    parameter logic [HDR_W-1:0] HDR    = 8'hA5,
    localparam int HIT_W = 2 * NCH,
    localparam int FW    = HDR_W + BCID_W + HIT_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_start,
    input  logic             bx_tick,
    input  logic             trig,
    input  logic [HIT_W-1:0] hits,
    input  logic             rd_req,
    input  logic             rd_tick,
    output logic             ser_out,
    output logic             ser_valid,
    output logic             rd_busy,
    output logic             mem_full,
    output logic [CW-1:0]    frame_cnt
);

    typedef struct packed {
        ctl_state_e    st;
        logic [CW-1:0] cnt;
        logic          bx_done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              wr_en;
    logic              start;
    logic              frame_done;
    logic              full;
    logic [BCID_W-1:0] bcid_w;
    logic [FW-1:0]     wdata;
    logic [FW-1:0]     rdata;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;

    hit_bcid_ctr #(
        .W (BCID_W)
    ) u_bcid (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (acq_start),
        .tick (bx_tick),
        .bcid (bcid_w)
    );

    assign full  = (c_q.cnt == CW'(DEPTH));
    assign waddr = AW'(c_q.cnt);
    assign raddr = AW'(c_q.cnt - CW'(1));
    assign wdata = {HDR, bcid_w, hits};

    always_comb begin
        c_d   = c_q;
        wr_en = 1'b0;
        start = 1'b0;
        if (acq_start) begin
            c_d.st      = CTL_ACQ;
            c_d.cnt     = '0;
            c_d.bx_done = 1'b0;
        end else begin
            case (c_q.st)
                CTL_ACQ: begin
                    if (rd_req && (c_q.cnt != '0)) begin
                        c_d.st = CTL_READ;
                        start  = 1'b1;
                    end else if (trig && !c_q.bx_done && !full) begin
                        wr_en   = 1'b1;
                        c_d.cnt = c_q.cnt + CW'(1);
                    end
                end
                CTL_READ: begin
                    if (frame_done) begin
                        c_d.cnt = c_q.cnt - CW'(1);
                        if (c_q.cnt == CW'(1)) begin
                            c_d.st = CTL_ACQ;
                        end
                    end
                end
                default: c_d.st = CTL_ACQ;
            endcase
            c_d.bx_done = bx_tick ? 1'b0 : (c_q.bx_done | wr_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st      <= CTL_ACQ;
            c_q.cnt     <= '0;
            c_q.bx_done <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    hit_frame_store #(
        .FW   (FW),
        .DEPTH(DEPTH)
    ) u_store (
        .clk  (clk),
        .we   (wr_en),
        .waddr(waddr),
        .wdata(wdata),
        .raddr(raddr),
        .rdata(rdata)
    );

    hit_readout #(
        .FW(FW)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (acq_start),
        .start     (start),
        .tick      (rd_tick),
        .last_frame(c_q.cnt == CW'(1)),
        .frame_in  (rdata),
        .ser_out   (ser_out),
        .ser_valid (ser_valid),
        .frame_done(frame_done)
    );

    assign rd_busy   = (c_q.st == CTL_READ);
    assign mem_full  = full;
    assign frame_cnt = c_q.cnt;

endmodule

// File: rtl/hit_mem_chk.sv
module hit_mem_chk #(
    parameter int DEPTH  = 128,
    parameter int CW     = 8,
    parameter int BCID_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acq_start,
    input logic              bx_tick,
    input logic              rd_req,
    input logic              rd_tick,
    input logic              ser_out,
    input logic              ser_valid,
    input logic              rd_busy,
    input logic              mem_full,
    input logic [CW-1:0]     frame_cnt,
    input logic              wr_en,
    input logic [BCID_W-1:0] bcid
);

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !acq_start |=> frame_cnt == $past(frame_cnt) + CW'(1));

    p_one_per_bx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !bx_tick |=> !wr_en);

    p_bcid_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bx_tick && !acq_start |=> bcid == $past(bcid) + BCID_W'(1));

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= CW'(DEPTH));

    p_full_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_full |-> !wr_en);

    p_hold_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid && !rd_tick && !acq_start |=> ser_valid && $stable(ser_out));

    p_valid_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> rd_busy);

    p_no_wr_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |-> !wr_en);

    p_empty_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_busy && frame_cnt == '0 && !acq_start |=> !rd_busy);

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> !rd_busy && frame_cnt == '0 && bcid == '0);

endmodule

bind hit_mem_top hit_mem_chk #(
    .DEPTH (DEPTH),
    .CW    (CW),
    .BCID_W(BCID_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acq_start(acq_start),
    .bx_tick  (bx_tick),
    .rd_req   (rd_req),
    .rd_tick  (rd_tick),
    .ser_out  (ser_out),
    .ser_valid(ser_valid),
    .rd_busy  (rd_busy),
    .mem_full (mem_full),
    .frame_cnt(frame_cnt),
    .wr_en    (wr_en),
    .bcid     (bcid_w)
);

// File: tb/hit_mem_top_tb.sv
module hit_mem_top_tb;

    localparam int         NCH    = 4;
    localparam int         DEPTH  = 4;
    localparam int         BCID_W = 6;
    localparam logic [7:0] HDR    = 8'hC3;
    localparam int         HIT_W  = 2 * NCH;
    localparam int         FW     = 8 + BCID_W + HIT_W;
    localparam int         CW     = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acq_start = 1'b0;
    logic             bx_tick = 1'b0;
    logic             trig = 1'b0;
    logic [HIT_W-1:0] hits = '0;
    logic             rd_req = 1'b0;
    logic             rd_tick = 1'b0;
    logic             ser_out;
    logic             ser_valid;
    logic             rd_busy;
    logic             mem_full;
    logic [CW-1:0]    frame_cnt;

    int nchecks = 0;
    int nerrs   = 0;

    logic [FW-1:0]     exp_q[$];
    logic [BCID_W-1:0] m_bcid = '0;
    int                m_cnt  = 0;
    bit                m_bxd  = 1'b0;

    always #5 clk = ~clk;

    hit_mem_top #(
        .NCH   (NCH),
        .DEPTH (DEPTH),
        .BCID_W(BCID_W),
        .HDR   (HDR)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq_start(acq_start),
        .bx_tick  (bx_tick),
        .trig     (trig),
        .hits     (hits),
        .rd_req   (rd_req),
        .rd_tick  (rd_tick),
        .ser_out  (ser_out),
        .ser_valid(ser_valid),
        .rd_busy  (rd_busy),
        .mem_full (mem_full),
        .frame_cnt(frame_cnt)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nerrs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bx_pulse();
        @(posedge clk); #2 bx_tick = 1'b1;
        @(posedge clk); #2 bx_tick = 1'b0;
        m_bcid = m_bcid + BCID_W'(1);
        m_bxd  = 1'b0;
    endtask

    task automatic trig_pulse(input logic [HIT_W-1:0] h);
        @(posedge clk); #2 trig = 1'b1; hits = h;
        @(posedge clk); #2 trig = 1'b0;
        if (m_cnt < DEPTH && !m_bxd) begin
            exp_q.push_back({HDR, m_bcid, h});
            m_cnt++;
            m_bxd = 1'b1;
        end
    endtask

    task automatic acq_clear();
        @(posedge clk); #2 acq_start = 1'b1; rd_tick = 1'b0;
        @(posedge clk); #2 acq_start = 1'b0;
        m_bcid = '0;
        m_cnt  = 0;
        m_bxd  = 1'b0;
        exp_q.delete();
    endtask

    task automatic read_all(input bit gap, input bit trig_mid, input string req);
        int guard;
        @(posedge clk); #2 rd_req = 1'b1;
        @(posedge clk); #2 rd_req = 1'b0; rd_tick = 1'b1;
        guard = 0;
        while (rd_busy && guard < 5000) begin
            @(posedge clk); #2;
            trig = (trig_mid && guard == 0);
            hits = 8'h99;
            rd_tick = gap ? ~rd_tick : 1'b1;
            guard++;
        end
        rd_tick = 1'b0;
        trig    = 1'b0;
        check(guard < 5000, {req, " readout ends"}, guard, 0);
        m_cnt = 0;
        check(exp_q.size() == 0, "R6 all frames returned", exp_q.size(), 0);
        check(frame_cnt == '0, "R9 count empty after readout", frame_cnt, 0);
        check(!mem_full, "R9 full clear after readout", mem_full, 0);
    endtask

    // Monitor: collects serial bits and compares whole frames to the scoreboard
    initial begin
        logic [FW-1:0] acc;
        int nbits;
        acc   = '0;
        nbits = 0;
        forever begin
            @(negedge clk);
            if (acq_start) begin
                nbits = 0;
                acc   = '0;
            end else if (ser_valid && rd_tick) begin
                acc = {acc[FW-2:0], ser_out};
                nbits++;
                if (nbits == FW) begin
                    nbits = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 unexpected frame", acc, 0);
                    end else begin
                        logic [FW-1:0] e;
                        e = exp_q.pop_back();
                        check(acc == e, "R6 R7 frame content and order", acc, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R8 watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(frame_cnt == '0, "R1 reset count", frame_cnt, 0);
        check(!mem_full, "R1 reset full", mem_full, 0);
        check(!rd_busy, "R1 reset busy", rd_busy, 0);
        check(!ser_valid, "R1 reset valid", ser_valid, 0);

        // R2 and R3: store, then a second trigger in the same crossing
        repeat (3) bx_pulse();
        trig_pulse(8'h1B);
        check(frame_cnt == CW'(1), "R2 count after trigger", frame_cnt, 1);
        trig_pulse(8'hE4);
        check(frame_cnt == CW'(1), "R3 second trigger same crossing", frame_cnt, 1);
        bx_pulse();
        trig_pulse(8'h72);
        check(frame_cnt == CW'(2), "R2 count after new crossing", frame_cnt, 2);
        read_all(1'b0, 1'b0, "R6");

        // R10: request with nothing stored
        @(posedge clk); #2 rd_req = 1'b1;
        @(posedge clk); #2 rd_req = 1'b0;
        @(negedge clk);
        check(!rd_busy, "R10 empty request busy", rd_busy, 0);
        check(!ser_valid, "R10 empty request valid", ser_valid, 0);

        // R5: fill the buffer, then one more trigger
        bx_pulse();
        for (int i = 0; i < DEPTH; i++) begin
            trig_pulse(HIT_W'(i * 8'h35 + 1));
            bx_pulse();
        end
        check(mem_full, "R5 full after DEPTH frames", mem_full, 1);
        trig_pulse(8'hFF);
        check(frame_cnt == CW'(DEPTH), "R5 trigger ignored when full", frame_cnt, DEPTH);
        read_all(1'b1, 1'b0, "R8");

        // R4: crossing number wraps; R9: trigger during readout ignored
        repeat (70) bx_pulse();
        trig_pulse(8'h5A);
        bx_pulse();
        read_all(1'b0, 1'b1, "R9");

        // R11: acquisition start clears count and crossing number
        repeat (5) bx_pulse();
        trig_pulse(8'h0F);
        acq_clear();
        check(frame_cnt == '0, "R11 count cleared", frame_cnt, 0);
        trig_pulse(8'h3C);
        check(frame_cnt == CW'(1), "R11 trigger after clear stores", frame_cnt, 1);
        read_all(1'b0, 1'b0, "R4");

        // R11: abort a readout part way through a frame
        bx_pulse();
        trig_pulse(8'h81);
        bx_pulse();
        trig_pulse(8'h42);
        @(posedge clk); #2 rd_req = 1'b1;
        @(posedge clk); #2 rd_req = 1'b0; rd_tick = 1'b1;
        repeat (5) @(posedge clk);
        acq_clear();
        @(negedge clk);
        check(!rd_busy, "R11 abort busy", rd_busy, 0);
        check(!ser_valid, "R11 abort valid", ser_valid, 0);
        check(frame_cnt == '0, "R11 abort count", frame_cnt, 0);
        bx_pulse();
        trig_pulse(8'hA6);
        read_all(1'b0, 1'b0, "R11");

        $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
        $finish;
    end

endmodule